// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block receives characters from an asynchronous serial line that rests at logic 1. It watches the line for a falling edge, confirms the start bit at its centre, and then samples each following bit at its midpoint. It runs from a 16x oversampling enable supplied from outside. Eight data bits arrive least significant first. An optional parity bit may follow them, and a single stop bit closes the frame. A finished character goes into a holding register. A small set of status flags and two level interrupt requests tell the host what happened.

Each completion event chooses on its own whether the character reaches the holding register. A character that arrives while the previous one is still unread is dropped and flagged as an overrun. A character with a bad parity bit or a low stop bit is still stored, and the matching error flag is raised. The host empties the register with a read strobe. It clears error flags by writing zeros to their bits. While any error flag stands, the receiver refuses to begin a new frame.

Top module: `uart_rx_core`

## Requirements
- R1: After synchronous reset the holding register reads 0, all four flags (ready, overrun, framing, parity) read 0 and both interrupt requests are low.
- R2: A frame consists of a 0 start bit, 8 data bits with the least significant first, an optional parity bit and a 1 stop bit. An error-free character is loaded into `rx_data` and sets `rdy`.
- R3: A low pulse on the line that has ended before the middle of the start bit (8 ticks after detection) does not begin a frame and changes no output.
- R4: With `par_en`=1, a parity bit follows bit 7. `par_odd`=0 expects an even total count of ones over data plus parity, and `par_odd`=1 expects an odd count. With `par_en`=0 the stop bit directly follows bit 7.
- R5: A parity mismatch sets `per` and loads the character into `rx_data` without setting `rdy`.
- R6: A stop bit sampled as 0 sets `fer` and loads the character into `rx_data` without setting `rdy`.
- R7: A character that completes while `rdy` is 1 sets `ovr`, leaves `rx_data` unchanged and leaves `rdy` at 1.
- R8: A one-cycle `rd_stb` clears `rdy`. A character that follows with no idle gap is received without loss when the read happens before that character completes.
- R9: A `wr_stb` cycle clears each error flag whose bit in `wr_flags` is 0. The bit positions are [0] overrun, [1] framing and [2] parity. A bit written as 1 leaves its flag unchanged.
- R10: While any of `ovr`, `fer` or `per` is 1, complete frames on the line are ignored and no output changes.
- R11: `irq_rxf` equals `rx_ie` AND `rdy`. `irq_err` equals `rx_ie` AND (`ovr` OR `fer` OR `per`).
- R12: Bit timing advances only on cycles where `tick_en` is 1. One bit lasts 16 ticks, whatever the spacing of the ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | Parity bit present in frame |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_stb | input | 1 | Host read of data, clears ready |
| wr_stb | input | 1 | Host write to error flags |
| wr_flags | input | 3 | Write value: [0] overrun, [1] framing, [2] parity |
| rx_data | output | 8 | Receive holding register |
| rdy | output | 1 | Data-ready flag |
| ovr | output | 1 | Overrun flag |
| fer | output | 1 | Framing-error flag |
| per | output | 1 | Parity-error flag |
| irq_rxf | output | 1 | Receive-full interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |

## Verification
The hardest case to reach is back-to-back reception: the host read has to land while the next character is already mid-frame, with no idle time between the stop bit of one frame and the start bit of the next. The bench reaches it by running the frame sender and a delayed host read in parallel. A second hard case is the suspended receiver. A complete, well-formed frame is sent while an error flag is set, and the bench confirms that neither the data nor the flags move. A reference model that tracks flags and data behaviourally is compared against the outputs every clock, except inside the stop bit where the update instant may fall.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DEF_DATA_W = 8;
    localparam int DEF_OVS    = 16;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_PAR   = 3'd3,
        S_STOP  = 3'd4
    } rx_state_t;

    // bit order matches the host write value: [2] parity, [1] framing, [0] overrun
    typedef struct packed {
        logic per;
        logic fer;
        logic ovr;
    } rx_err_t;

    // 1 when the sampled parity bit disagrees with the expected one
    function automatic logic parity_bad(input logic sampled, input logic ones_xor,
                                        input logic odd_sel);
        return sampled != (ones_xor ^ odd_sel);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int OVS    = DEF_OVS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              rx_s,
    input  logic              hold,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [BIT_W-1:0] TOP  = BIT_W'(DATA_W - 1);

    rx_state_t         st;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bidx;
    logic [DATA_W-1:0] sh;
    logic              perr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            sh     <= '0;
            perr_q <= 1'b0;
        end else if (tick_en) begin
            case (st)
                S_IDLE: begin
                    if (!hold && !rx_s) begin
                        st  <= S_START;
                        cnt <= '0;
                    end
                end
                S_START: begin
                    if (cnt == MID) begin
                        cnt <= '0;
                        if (!rx_s) begin
                            st     <= S_DATA;
                            bidx   <= '0;
                            perr_q <= 1'b0;
                        end else begin
                            st <= S_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (cnt == LAST) begin
                        cnt <= '0;
                        sh  <= {rx_s, sh[DATA_W-1:1]};
                        if (bidx == TOP) st <= par_en ? S_PAR : S_STOP;
                        else             bidx <= bidx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_PAR: begin
                    if (cnt == LAST) begin
                        cnt    <= '0;
                        perr_q <= parity_bad(rx_s, ^sh, par_odd);
                        st     <= S_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_STOP: begin
                    if (cnt == LAST) begin
                        cnt <= '0;
                        st  <= S_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign done = tick_en && (st == S_STOP) && (cnt == LAST);
    assign data = sh;
    assign perr = par_en && perr_q;
    assign ferr = !rx_s;

    // timing moves only on ticks
    p_tick_gate_r12: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(st) && $stable(cnt));

    // no new frame starts while the status side holds us
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (hold && st == S_IDLE) |=> st == S_IDLE);

    // the start phase never runs past mid-bit
    p_start_mid_r3: assert property (@(posedge clk) disable iff (rst)
        (st == S_START) |-> cnt <= MID);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [DATA_W-1:0] din,
    input  logic              perr,
    input  logic              ferr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [2:0]        wr_flags,
    input  logic              rx_ie,
    output logic [DATA_W-1:0] data_q,
    output logic              rdy,
    output rx_err_t           err_q,
    output logic              hold,
    output logic              irq_rxf,
    output logic              irq_err
);
    rx_err_t wr_v;
    logic    rdy_eff;

    assign wr_v    = rx_err_t'(wr_flags);
    assign rdy_eff = rdy && !rd_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            rdy    <= 1'b0;
            err_q  <= '0;
        end else begin
            if (rd_stb) rdy <= 1'b0;
            if (wr_stb) begin
                if (err_q.ovr && !wr_v.ovr) err_q.ovr <= 1'b0;
                if (err_q.fer && !wr_v.fer) err_q.fer <= 1'b0;
                if (err_q.per && !wr_v.per) err_q.per <= 1'b0;
            end
            if (done) begin
                if (rdy_eff) begin
                    err_q.ovr <= 1'b1;
                end else begin
                    data_q <= din;
                    if (perr || ferr) begin
                        if (perr) err_q.per <= 1'b1;
                        if (ferr) err_q.fer <= 1'b1;
                    end else begin
                        rdy <= 1'b1;
                    end
                end
            end
        end
    end

    assign hold    = |err_q;
    assign irq_rxf = rx_ie && rdy;
    assign irq_err = rx_ie && hold;

    p_ovr_keeps_data_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q.ovr) |-> $stable(data_q));

    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !done) |=> !rdy);

    p_write_one_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_flags[2] && err_q.per) |=> err_q.per);

    p_fer_from_frame_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q.fer) |-> $past(done));
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int OVS     = DEF_OVS,
    parameter int SYNC_ST = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              rxd,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rx_ie,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [2:0]        wr_flags,
    output logic [DATA_W-1:0] rx_data,
    output logic              rdy,
    output logic              ovr,
    output logic              fer,
    output logic              per,
    output logic              irq_rxf,
    output logic              irq_err
);
    logic              rx_s;
    logic              hold;
    logic              done;
    logic [DATA_W-1:0] fr_data;
    logic              fr_perr;
    logic              fr_ferr;
    rx_err_t           err;

    uart_rx_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rxd),
        .dout(rx_s)
    );

    uart_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .tick_en(tick_en),
        .rx_s   (rx_s),
        .hold   (hold),
        .par_en (par_en),
        .par_odd(par_odd),
        .done   (done),
        .data   (fr_data),
        .perr   (fr_perr),
        .ferr   (fr_ferr)
    );

    uart_rx_status #(.DATA_W(DATA_W)) u_status (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .din     (fr_data),
        .perr    (fr_perr),
        .ferr    (fr_ferr),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .wr_flags(wr_flags),
        .rx_ie   (rx_ie),
        .data_q  (rx_data),
        .rdy     (rdy),
        .err_q   (err),
        .hold    (hold),
        .irq_rxf (irq_rxf),
        .irq_err (irq_err)
    );

    assign ovr = err.ovr;
    assign fer = err.fer;
    assign per = err.per;
endmodule

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       rxd = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rx_ie = 1'b0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [2:0] wr_flags = 3'b111;
    logic [7:0] rx_data;
    logic       rdy, ovr, fer, per, irq_rxf, irq_err;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_div = 1;
    int tdc      = 0;
    bit chk_en   = 1'b0;
    bit finished = 1'b0;

    // reference model state
    logic [7:0] m_data = 8'h00;
    bit m_rdy = 0, m_ovr = 0, m_fer = 0, m_per = 0;

    always #5 clk = ~clk;

    uart_rx_core i_uart_rx_core (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rxd(rxd),
        .par_en(par_en), .par_odd(par_odd), .rx_ie(rx_ie),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_flags(wr_flags),
        .rx_data(rx_data), .rdy(rdy), .ovr(ovr), .fer(fer), .per(per),
        .irq_rxf(irq_rxf), .irq_err(irq_err)
    );

    // tick generator, one tick every tick_div clocks
    always @(negedge clk) begin
        tdc = tdc + 1;
        if (tdc >= tick_div) begin
            tdc = 0;
            tick_en = 1'b1;
        end else begin
            tick_en = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (chk_en && !rst) begin
            chk("R2 rdy", rdy, m_rdy);
            chk("R2 rx_data", rx_data, m_data);
            chk("R7 ovr", ovr, m_ovr);
            chk("R6 fer", fer, m_fer);
            chk("R5 per", per, m_per);
            chk("R11 irq_rxf", irq_rxf, rx_ie & m_rdy);
            chk("R11 irq_err", irq_err, rx_ie & (m_ovr | m_fer | m_per));
        end
    end

    function automatic void model_frame(input logic [7:0] d, input bit pe, input bit fe);
        if (m_ovr || m_fer || m_per) return;      // R10 suspended
        if (m_rdy) begin
            m_ovr = 1;                            // R7
        end else begin
            m_data = d;
            if (pe || fe) begin
                if (pe) m_per = 1;
                if (fe) m_fer = 1;
            end else begin
                m_rdy = 1;
            end
        end
    endfunction

    task automatic line_bit(input logic b);
        rxd = b;
        repeat (16 * tick_div) @(negedge clk);
    endtask

    // sends one frame starting at a negedge; ends at the end of the stop bit
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        logic pb;
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(d[i]);
        if (par_en) begin
            pb = (^d) ^ par_odd ^ bad_par;
            line_bit(pb);
        end
        chk_en = 1'b0;
        line_bit(bad_stop ? 1'b0 : 1'b1);
        rxd = 1'b1;
        model_frame(d, par_en && bad_par, bad_stop);
        chk_en = 1'b1;
    endtask

    task automatic idle(input int n);
        rxd = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic host_read(input string tag, input logic [7:0] exp);
        @(negedge clk);
        chk(tag, rx_data, exp);
        rd_stb = 1'b1;
        @(posedge clk);
        #1 rd_stb = 1'b0;
        m_rdy = 0;
    endtask

    task automatic host_write(input logic [2:0] v);
        @(negedge clk);
        wr_flags = v;
        wr_stb = 1'b1;
        @(posedge clk);
        #1 wr_stb = 1'b0;
        wr_flags = 3'b111;
        if (!v[0]) m_ovr = 0;
        if (!v[1]) m_fer = 0;
        if (!v[2]) m_per = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 data", rx_data, 8'h00);
        chk("R1 flags", {rdy, ovr, fer, per}, 4'b0000);
        chk("R1 irqs", {irq_rxf, irq_err}, 2'b00);
        chk_en = 1'b1;
        rx_ie = 1'b1;
        idle(20);

        // R2 plain character, no parity
        send_frame(8'hA5, 0, 0);
        idle(10);
        chk("R2 ready after frame", rdy, 1'b1);
        chk("R11 irq_rxf up", irq_rxf, 1'b1);
        host_read("R8 read data", 8'hA5);
        idle(3);
        chk("R8 ready cleared", rdy, 1'b0);

        // R3 short glitch is rejected
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        idle(60);
        chk("R3 glitch no ready", rdy, 1'b0);

        // R4 parity even and odd, good bits
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h3C, 0, 0);
        idle(10);
        host_read("R4 even parity", 8'h3C);
        par_odd = 1'b1;
        send_frame(8'h81, 0, 0);
        idle(10);
        chk("R4 odd parity ready", rdy, 1'b1);
        host_read("R4 odd parity", 8'h81);

        // R5 parity mismatch
        send_frame(8'h55, 1, 0);
        idle(10);
        chk("R5 per set", per, 1'b1);
        chk("R5 data delivered", rx_data, 8'h55);
        chk("R5 no ready", rdy, 1'b0);
        // R10 suspended while error stands
        send_frame(8'h12, 0, 0);
        idle(10);
        chk("R10 data kept", rx_data, 8'h55);
        // R9 writing 1 keeps, writing 0 clears
        host_write(3'b100);
        idle(2);
        chk("R9 write one keeps per", per, 1'b1);
        host_write(3'b000);
        idle(2);
        chk("R9 write zero clears per", per, 1'b0);

        // R6 framing error
        par_en = 1'b0;
        send_frame(8'hF0, 0, 1);
        idle(10);
        chk("R6 fer set", fer, 1'b1);
        chk("R6 data delivered", rx_data, 8'hF0);
        host_write(3'b101);
        idle(2);
        chk("R9 fer cleared", fer, 1'b0);

        // R7 overrun
        send_frame(8'h11, 0, 0);
        idle(5);
        send_frame(8'h22, 0, 0);
        idle(10);
        chk("R7 ovr set", ovr, 1'b1);
        chk("R7 ready kept", rdy, 1'b1);
        host_read("R7 old data kept", 8'h11);
        host_write(3'b110);
        idle(2);
        chk("R9 ovr cleared", ovr, 1'b0);

        // R8 back-to-back with a read during the second frame
        send_frame(8'h33, 0, 0);
        fork
            send_frame(8'h44, 0, 0);
            begin
                repeat (40) @(negedge clk);
                host_read("R8 first of pair", 8'h33);
            end
        join
        idle(10);
        chk("R8 no overrun", ovr, 1'b0);
        host_read("R8 second of pair", 8'h44);

        // R11 interrupts gated off
        rx_ie = 1'b0;
        send_frame(8'h66, 0, 0);
        idle(10);
        chk("R11 irq_rxf gated", irq_rxf, 1'b0);
        host_read("R11 data", 8'h66);
        rx_ie = 1'b1;

        // R12 slower tick spacing
        tick_div = 2;
        idle(10);
        send_frame(8'h9E, 0, 0);
        idle(20);
        chk("R12 ready at half tick rate", rdy, 1'b1);
        host_read("R12 data", 8'h9E);
        idle(10);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule